// File: doc/BRIEF.md
# Digital I/O Port Register File

This block is the byte-wide register file of a 56-line digital I/O card. It is reached through a simple bus with a 4-bit address, a write strobe with 8-bit write data, and an 8-bit read data path. The read data follows the address combinationally. Twenty-four output lines are split into three latched banks. Twenty-four isolated input lines are split into three read-only banks. One 8-line logic-level bank can be switched between input and output. A mode bit in a control byte sets the direction of that whole bank.

Every input pin passes through a synchronizer before software can read it. A byte that enables change-of-state detection is stored here and driven out to a separate detection block. A write to the top address resets the board. Software reset clears every latch here and also sends a one-cycle pulse to the neighbouring logic. A read of that same address returns the interrupt pin level, which the detection block supplies.

Top module: `dio_port_regfile`

## Requirements
- R1: Writes to addresses 0x0, 0x1 and 0x2 load output banks 0, 1 and 2. Bank k drives `outLines[8k+7:8k]` from the next clock edge. A read of each of these addresses returns its latch.
- R2: Reads of 0x4, 0x5 and 0x6 return input bits 7:0, 15:8 and 23:16 after a two-stage synchronizer. A pin change is visible after the second rising edge and not after the first.
- R3: Writes to 0x4 through 0x7 change no output, no latch and no readable register.
- R4: Control byte at 0xC: bit 1 set selects output mode for the bidirectional bank, and bit 1 clear selects input mode. A read returns bit 1 in place, with every other bit reading 0.
- R5: In output mode `bidirOe` is 0xFF and `bidirOut` equals the latch at 0x3. In input mode both are 0x00. The latch at 0x3 accepts writes in either mode, and a read of 0x3 returns it.
- R6: A read of 0x7 returns the synchronized bidirectional pin levels in both modes.
- R7: Address 0xE holds the change-of-state enable byte. It reads back as written and drives `cosEnable`.
- R8: A write of any value to 0xF clears all output latches, the bidirectional latch, the mode bit and the enable byte at that edge. It raises `boardRstPulse` for exactly the following cycle. A read of 0xF returns `{7'b0, irqPin}`.
- R9: After hardware reset, all outputs and registers are zero, so the bidirectional bank starts in input mode.
- R10: Reads of 0x8 to 0xB and 0xD return 0x00. Writes to those addresses have no effect here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| isoIn | input | 24 | Isolated input pins |
| bidirIn | input | 8 | Bidirectional bank pin levels |
| irqPin | input | 1 | Interrupt output level from the detection block |
| outLines | output | 24 | Latched output lines |
| bidirOut | output | 8 | Bidirectional bank drive value |
| bidirOe | output | 8 | Bidirectional bank output enables |
| cosEnable | output | 8 | Change-of-state enable byte |
| boardRstPulse | output | 1 | One-cycle pulse after a software reset |

## Verification
The output banks are loaded with distinct asymmetric bytes, so any swap of bank order or bit order shows up on `outLines`. The input banks are driven with two different patterns and read one edge and two edges after each change; this separates a correct two-stage synchronizer from a missing or extra stage. Writes to the input, reserved and status addresses are followed by a full readback and an output check, which exposes stray decodes. The software reset is issued with every register non-zero, and the bench checks both the cleared state and the single-cycle pulse.

// File: rtl/dio_regfile_pkg.sv
package dio_regfile_pkg;
  localparam int BANK_W     = 8;
  localparam int OUT_BANKS  = 3;
  localparam int IN_BANKS   = 3;
  localparam int ADDR_W     = 4;
  localparam int OUT_W      = BANK_W * OUT_BANKS;
  localparam int IN_W       = BANK_W * IN_BANKS;
  localparam int MAX_BANKS  = (OUT_BANKS > IN_BANKS) ? OUT_BANKS : IN_BANKS;
  localparam int BANK_IDX_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1;
  localparam int MODE_BIT   = 1;

  localparam logic [ADDR_W-1:0] ADR_OUT_BASE    = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_BIDIR_LATCH = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_IN_BASE     = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_BIDIR_PIN   = 4'h7;
  localparam logic [ADDR_W-1:0] ADR_MODE        = 4'hC;
  localparam logic [ADDR_W-1:0] ADR_RSVD        = 4'hD;
  localparam logic [ADDR_W-1:0] ADR_COS_EN      = 4'hE;
  localparam logic [ADDR_W-1:0] ADR_BOARD_RST   = 4'hF;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_OUT,
    SEL_BIDIR_LATCH,
    SEL_IN,
    SEL_BIDIR_PIN,
    SEL_MODE,
    SEL_COS_EN,
    SEL_IRQ
  } rdSel_e;

  typedef struct packed {
    logic [OUT_BANKS-1:0] wrOut;
    logic                 wrBidir;
    logic                 wrMode;
    logic                 wrCosEn;
    logic                 boardRst;
  } wrStrobe_t;
endpackage

// File: rtl/dio_regfile_ctrl.sv
module dio_regfile_ctrl
  import dio_regfile_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  output wrStrobe_t             strb,
  output rdSel_e                rdSel,
  output logic [BANK_IDX_W-1:0] bankIdx
);
  logic [ADDR_W-1:0] outOfs;
  logic [ADDR_W-1:0] inOfs;
  logic              isOutBank;
  logic              isInBank;

  assign outOfs    = busAddr - ADR_OUT_BASE;
  assign inOfs     = busAddr - ADR_IN_BASE;
  assign isOutBank = outOfs < ADDR_W'(OUT_BANKS);
  assign isInBank  = inOfs < ADDR_W'(IN_BANKS);

  // one write strobe per output bank
  for (genvar g = 0; g < OUT_BANKS; g++) begin : gOutStrobe
    assign strb.wrOut[g] = busWrEn && (outOfs == ADDR_W'(g));
  end

  assign strb.wrBidir  = busWrEn && (busAddr == ADR_BIDIR_LATCH);
  assign strb.wrMode   = busWrEn && (busAddr == ADR_MODE);
  assign strb.wrCosEn  = busWrEn && (busAddr == ADR_COS_EN);
  assign strb.boardRst = busWrEn && (busAddr == ADR_BOARD_RST);

  always_comb begin
    rdSel   = SEL_ZERO;
    bankIdx = '0;
    if (isOutBank) begin
      rdSel   = SEL_OUT;
      bankIdx = outOfs[BANK_IDX_W-1:0];
    end else if (isInBank) begin
      rdSel   = SEL_IN;
      bankIdx = inOfs[BANK_IDX_W-1:0];
    end else begin
      case (busAddr)
        ADR_BIDIR_LATCH: rdSel = SEL_BIDIR_LATCH;
        ADR_BIDIR_PIN:   rdSel = SEL_BIDIR_PIN;
        ADR_MODE:        rdSel = SEL_MODE;
        ADR_COS_EN:      rdSel = SEL_COS_EN;
        ADR_BOARD_RST:   rdSel = SEL_IRQ;
        default:         rdSel = SEL_ZERO;
      endcase
    end
  end

  // R1: at most one register is written per cycle
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R3: the input-side window 0x4..0x7 never produces a write strobe
  a_r3_input_window_silent: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (inOfs <= ADDR_W'(IN_BANKS))) |-> (strb == '0));

  // R10: the reserved and status addresses never produce a write strobe
  a_r10_reserved_silent: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == ADR_RSVD || busAddr[3:2] == 2'b10)) |-> (strb == '0));
endmodule

// File: rtl/dio_regfile_dpath.sv
module dio_regfile_dpath
  import dio_regfile_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wrStrobe_t             strb,
  input  rdSel_e                rdSel,
  input  logic [BANK_IDX_W-1:0] bankIdx,
  input  logic [BANK_W-1:0]     busWrData,
  input  logic [IN_W-1:0]       isoIn,
  input  logic [BANK_W-1:0]     bidirIn,
  input  logic                  irqPin,
  output logic [BANK_W-1:0]     busRdData,
  output logic [OUT_W-1:0]      outLines,
  output logic [BANK_W-1:0]     bidirOut,
  output logic [BANK_W-1:0]     bidirOe,
  output logic [BANK_W-1:0]     cosEnable,
  output logic                  boardRstPulse
);
  localparam int SYNC_W = IN_W + BANK_W;

  logic [BANK_W-1:0] outLatch [OUT_BANKS];
  logic [BANK_W-1:0] bidirLatch;
  logic              modeBit;
  logic [BANK_W-1:0] cosEnReg;
  logic              rstPulseQ;
  logic [SYNC_W-1:0] syncChain [SYNC_STAGES];
  logic [IN_W-1:0]   isoSync;
  logic [BANK_W-1:0] bidirSync;

  // output latches; a software reset wins over a write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < OUT_BANKS; b++) outLatch[b] <= '0;
      bidirLatch <= '0;
      modeBit    <= 1'b0;
      cosEnReg   <= '0;
    end else if (strb.boardRst) begin
      for (int b = 0; b < OUT_BANKS; b++) outLatch[b] <= '0;
      bidirLatch <= '0;
      modeBit    <= 1'b0;
      cosEnReg   <= '0;
    end else begin
      for (int b = 0; b < OUT_BANKS; b++)
        if (strb.wrOut[b]) outLatch[b] <= busWrData;
      if (strb.wrBidir) bidirLatch <= busWrData;
      if (strb.wrMode)  modeBit    <= busWrData[MODE_BIT];
      if (strb.wrCosEn) cosEnReg   <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPulseQ <= 1'b0;
    else       rstPulseQ <= strb.boardRst;
  end

  // pin synchronizer, cleared only by hardware reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= {bidirIn, isoIn};
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign isoSync   = syncChain[SYNC_STAGES-1][IN_W-1:0];
  assign bidirSync = syncChain[SYNC_STAGES-1][SYNC_W-1:IN_W];

  for (genvar g = 0; g < OUT_BANKS; g++) begin : gOutDrive
    assign outLines[g*BANK_W +: BANK_W] = outLatch[g];
  end

  assign bidirOe       = {BANK_W{modeBit}};
  assign bidirOut      = modeBit ? bidirLatch : '0;
  assign cosEnable     = cosEnReg;
  assign boardRstPulse = rstPulseQ;

  always_comb begin
    busRdData = '0;
    case (rdSel)
      SEL_OUT: begin
        for (int b = 0; b < OUT_BANKS; b++)
          if (bankIdx == BANK_IDX_W'(b)) busRdData = outLatch[b];
      end
      SEL_IN: begin
        for (int b = 0; b < IN_BANKS; b++)
          if (bankIdx == BANK_IDX_W'(b)) busRdData = isoSync[b*BANK_W +: BANK_W];
      end
      SEL_BIDIR_LATCH: busRdData = bidirLatch;
      SEL_BIDIR_PIN:   busRdData = bidirSync;
      SEL_MODE:        busRdData[MODE_BIT] = modeBit;
      SEL_COS_EN:      busRdData = cosEnReg;
      SEL_IRQ:         busRdData[0] = irqPin;
      default:         busRdData = '0;
    endcase
  end

  // R5: the bank switches direction as a whole
  a_r5_oe_uniform: assert property (@(posedge clk) disable iff (!rstN)
    (bidirOe == '0) || (bidirOe == '1));

  // R5: nothing is driven while the bank is an input
  a_r5_quiet_when_input: assert property (@(posedge clk) disable iff (!rstN)
    (bidirOe == '0) |-> (bidirOut == '0));

  // R8: software reset clears every driven register and pulses the reset output
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.boardRst |=> (outLines == '0 && bidirOe == '0 && cosEnable == '0 && boardRstPulse));

  // R7: enable byte changes only on its own write or a reset
  a_r7_enable_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrCosEn && !strb.boardRst) |=> $stable(cosEnable));

  // R1: output lines hold without a bank write or reset
  a_r1_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrOut == '0 && !strb.boardRst) |=> $stable(outLines));
endmodule

// File: rtl/dio_port_regfile.sv
module dio_port_regfile
  import dio_regfile_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BANK_W-1:0] busWrData,
  output logic [BANK_W-1:0] busRdData,
  input  logic [IN_W-1:0]   isoIn,
  input  logic [BANK_W-1:0] bidirIn,
  input  logic              irqPin,
  output logic [OUT_W-1:0]  outLines,
  output logic [BANK_W-1:0] bidirOut,
  output logic [BANK_W-1:0] bidirOe,
  output logic [BANK_W-1:0] cosEnable,
  output logic              boardRstPulse
);
  wrStrobe_t             strb;
  rdSel_e                rdSel;
  logic [BANK_IDX_W-1:0] bankIdx;

  dio_regfile_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb),
    .rdSel   (rdSel),
    .bankIdx (bankIdx)
  );

  dio_regfile_dpath #(.SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .rdSel         (rdSel),
    .bankIdx       (bankIdx),
    .busWrData     (busWrData),
    .isoIn         (isoIn),
    .bidirIn       (bidirIn),
    .irqPin        (irqPin),
    .busRdData     (busRdData),
    .outLines      (outLines),
    .bidirOut      (bidirOut),
    .bidirOe       (bidirOe),
    .cosEnable     (cosEnable),
    .boardRstPulse (boardRstPulse)
  );
endmodule

// File: tb/dio_port_regfile_test.sv
module dio_port_regfile_test;
  import dio_regfile_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [BANK_W-1:0] busWrData = '0;
  logic [BANK_W-1:0] busRdData;
  logic [IN_W-1:0]   isoIn = '0;
  logic [BANK_W-1:0] bidirIn = '0;
  logic              irqPin = 1'b0;
  logic [OUT_W-1:0]  outLines;
  logic [BANK_W-1:0] bidirOut;
  logic [BANK_W-1:0] bidirOe;
  logic [BANK_W-1:0] cosEnable;
  logic              boardRstPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dio_port_regfile uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .isoIn(isoIn),
    .bidirIn(bidirIn), .irqPin(irqPin), .outLines(outLines),
    .bidirOut(bidirOut), .bidirOe(bidirOe), .cosEnable(cosEnable),
    .boardRstPulse(boardRstPulse)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [BANK_W-1:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, output logic [BANK_W-1:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic readCheck(string tag, logic [ADDR_W-1:0] a, logic [BANK_W-1:0] exp);
    logic [BANK_W-1:0] d;
    busRead(a, d);
    check(tag, {24'h0, d}, {24'h0, exp});
  endtask

  task automatic testResetState();
    check("R9 outLines", {8'h0, outLines}, 32'h0);
    check("R9 bidirOe", {24'h0, bidirOe}, 32'h0);
    check("R9 cosEnable", {24'h0, cosEnable}, 32'h0);
    check("R9 pulse", {31'h0, boardRstPulse}, 32'h0);
    readCheck("R9 mode", ADR_MODE, 8'h00);
    readCheck("R9 bidir latch", ADR_BIDIR_LATCH, 8'h00);
  endtask

  task automatic testOutBanks();
    busWrite(4'h0, 8'hA5);
    busWrite(4'h1, 8'h3C);
    busWrite(4'h2, 8'hF0);
    check("R1 outLines", {8'h0, outLines}, 32'h00F03CA5);
    readCheck("R1 bank0", 4'h0, 8'hA5);
    readCheck("R1 bank1", 4'h1, 8'h3C);
    readCheck("R1 bank2", 4'h2, 8'hF0);
    busWrite(4'h1, 8'h81);
    check("R1 single bank update", {8'h0, outLines}, 32'h00F081A5);
  endtask

  task automatic testInputs(logic [IN_W-1:0] pat, logic [IN_W-1:0] prev);
    @(negedge clk);
    isoIn = pat;
    @(negedge clk);
    readCheck("R2 one edge old", 4'h4, prev[7:0]);
    @(negedge clk);
    readCheck("R2 bank0", 4'h4, pat[7:0]);
    readCheck("R2 bank1", 4'h5, pat[15:8]);
    readCheck("R2 bank2", 4'h6, pat[23:16]);
  endtask

  task automatic testInputWritesIgnored();
    for (int a = 4; a < 8; a++) busWrite(ADDR_W'(a), 8'hFF);
    check("R3 outLines", {8'h0, outLines}, 32'h00F081A5);
    check("R3 bidirOe", {24'h0, bidirOe}, 32'h0);
    check("R3 cosEnable", {24'h0, cosEnable}, 32'h0);
    readCheck("R3 bidir latch", ADR_BIDIR_LATCH, 8'h00);
    readCheck("R3 mode", ADR_MODE, 8'h00);
    readCheck("R3 input still pins", 4'h4, isoIn[7:0]);
  endtask

  task automatic testBidir();
    busWrite(ADR_BIDIR_LATCH, 8'h96);
    check("R5 input mode oe", {24'h0, bidirOe}, 32'h0);
    check("R5 input mode out", {24'h0, bidirOut}, 32'h0);
    readCheck("R5 latch readback", ADR_BIDIR_LATCH, 8'h96);
    busWrite(ADR_MODE, 8'hFF);
    readCheck("R4 mode readback", ADR_MODE, 8'h02);
    check("R5 output mode oe", {24'h0, bidirOe}, 32'hFF);
    check("R5 output mode out", {24'h0, bidirOut}, 32'h96);
    busWrite(ADR_MODE, 8'hFD);
    readCheck("R4 bit1 clear", ADR_MODE, 8'h00);
    check("R4 input mode oe", {24'h0, bidirOe}, 32'h0);
    busWrite(ADR_MODE, 8'h02);
    check("R4 bit1 only", {24'h0, bidirOe}, 32'hFF);
  endtask

  task automatic testBidirPins();
    @(negedge clk);
    bidirIn = 8'h5A;
    @(negedge clk);
    @(negedge clk);
    readCheck("R6 pins in output mode", ADR_BIDIR_PIN, 8'h5A);
    busWrite(ADR_MODE, 8'h00);
    bidirIn = 8'hC3;
    @(negedge clk);
    @(negedge clk);
    readCheck("R6 pins in input mode", ADR_BIDIR_PIN, 8'hC3);
    readCheck("R6 latch kept", ADR_BIDIR_LATCH, 8'h96);
  endtask

  task automatic testCosEnable();
    busWrite(ADR_COS_EN, 8'h12);
    readCheck("R7 readback", ADR_COS_EN, 8'h12);
    check("R7 port", {24'h0, cosEnable}, 32'h12);
    busWrite(ADR_COS_EN, 8'hED);
    readCheck("R7 readback 2", ADR_COS_EN, 8'hED);
    check("R7 port 2", {24'h0, cosEnable}, 32'hED);
  endtask

  task automatic testReserved();
    for (int a = 8; a < 12; a++) readCheck("R10 status reads zero", ADDR_W'(a), 8'h00);
    readCheck("R10 reserved reads zero", ADR_RSVD, 8'h00);
    busWrite(ADR_RSVD, 8'hFF);
    for (int a = 8; a < 12; a++) busWrite(ADDR_W'(a), 8'hFF);
    check("R10 outLines", {8'h0, outLines}, 32'h00F081A5);
    check("R10 cosEnable", {24'h0, cosEnable}, 32'hED);
    readCheck("R10 reserved after write", ADR_RSVD, 8'h00);
    readCheck("R10 mode", ADR_MODE, 8'h00);
  endtask

  task automatic testBoardReset();
    irqPin = 1'b1;
    readCheck("R8 irq high", ADR_BOARD_RST, 8'h01);
    irqPin = 1'b0;
    readCheck("R8 irq low", ADR_BOARD_RST, 8'h00);
    busWrite(ADR_MODE, 8'h02);
    check("R8 pre pulse", {31'h0, boardRstPulse}, 32'h0);
    busWrite(ADR_BOARD_RST, 8'h00);
    check("R8 pulse", {31'h0, boardRstPulse}, 32'h1);
    check("R8 outLines", {8'h0, outLines}, 32'h0);
    check("R8 oe", {24'h0, bidirOe}, 32'h0);
    check("R8 cosEnable", {24'h0, cosEnable}, 32'h0);
    readCheck("R8 bidir latch", ADR_BIDIR_LATCH, 8'h00);
    readCheck("R8 mode", ADR_MODE, 8'h00);
    readCheck("R8 inputs kept", 4'h6, isoIn[23:16]);
    @(negedge clk);
    check("R8 pulse single", {31'h0, boardRstPulse}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testOutBanks();
    testInputs(24'h123456, 24'h000000);
    testInputs(24'hA55AFF, 24'h123456);
    testInputWritesIgnored();
    testBidir();
    testBidirPins();
    testCosEnable();
    testReserved();
    testBoardReset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule